// File: doc/BRIEF.md
# GPIO Interrupt Latch with Split Enables

This block watches a bank of GPIO inputs and reduces them to a single summary interrupt for a CPU-side interrupt controller. Every input goes through a multi-flop synchronizer and then a per-pin trigger detector. The detector is configured for either a level or an edge trigger, and a per-pin polarity bit sets which level or which transition counts as active. When a trigger is detected it sets a sticky status bit. Software clears that bit by writing a one to it.

Each pin has two enable bits that act separately. The capture enable decides whether a detected trigger may set the status bit at all. The report enable decides whether a status bit that is already set may drive the summary line. A level source that is still active re-latches its status as soon as it is acknowledged, unless its capture enable is cleared. Clearing only the report enable hides the interrupt from the summary line but leaves the pending status in place.

A simple synchronous register bus gives access to one configuration word per pin and to one packed status word. Reads are combinational from the address.

Top module: `gpio_irq_latch`

## Requirements
- R1: After reset, every configuration word reads 0, the status word reads 0 and `irq_o` is 0.
- R2: While a pin's capture enable (config bit 2) is 0, no trigger on that pin sets its status bit, whatever the report enable holds.
- R3: While a pin's report enable (config bit 3) is 0, its status bit still latches, but it does not raise `irq_o`.
- R4: A status bit stays set after its source goes inactive. Only a bus write to the status address with a 1 in that bit position clears it. A 0 in that position leaves the bit unchanged.
- R5: If an acknowledge arrives in the same cycle as a detected trigger on a capture-enabled pin, the set wins. A level pin whose input is still active therefore stays pending through an acknowledge.
- R6: `irq_o` is a register. It is 1 in the cycle after some pin has both its status bit and its report enable set, and it returns to 0 one cycle after the last such pin stops qualifying.
- R7: A pin in edge mode (config bit 0 = 0) latches only on the transition chosen by its polarity bit: bit 1 = 1 selects rising, bit 1 = 0 selects falling. A held level or the opposite transition latches nothing.
- R8: In edge mode, raising the capture enable while the input is held at its active level does not by itself produce an event. The edge history keeps tracking the input while capture is disabled.
- R9: With the default two synchronizer stages, an input change applied between clock edges shows in the status bit after the third rising edge, and in `irq_o` after the fourth.
- R10: The configuration word of pin i sits at address i, with bit 0 = level mode, bit 1 = active-high/rising polarity, bit 2 = capture enable and bit 3 = report enable. A level pin with bit 1 = 0 is active low. The status word sits at address NUM_PINS with bit i belonging to pin i. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_i | input | NUM_PINS | Asynchronous GPIO inputs |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data (DATA_W = max(NUM_PINS, 4)) |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Registered summary interrupt |

## Verification
The bench uses the defaults: eight pins, a four-bit address and two synchronizer stages. With these values the three-edge input-to-status latency and the four-edge input-to-interrupt latency can be checked to the exact cycle. Eight pins are enough to give each scenario its own pin, so level high, level low, rising, falling, capture-disabled, report-disabled and capture-re-armed cases run without sharing state. The four-bit address leaves addresses 9 to 15 unmapped, so the zero read-back on unused addresses can be checked.

// File: rtl/gil_pkg.sv
package gil_pkg;

   localparam int CFG_W = 4;

   // bit 0 level mode, bit 1 polarity, bit 2 capture enable, bit 3 report enable
   typedef struct packed {
      logic rpt_en;
      logic cap_en;
      logic pol;
      logic lvl;
   } pin_cfg_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/gil_sync.sv
module gil_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gil_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/gil_pin_detect.sv
module gil_pin_detect
   import gil_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     smp_i,
   input  pin_cfg_t cfg_i,
   input  logic     clr_i,
   output logic     prev_o,
   output logic     trig_o,
   output logic     status_o
);

   logic prev_q;
   logic status_q;
   logic rise;
   logic fall;

   // history follows the input regardless of capture enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= smp_i;
   end

   assign rise = smp_i & ~prev_q;
   assign fall = ~smp_i & prev_q;

   always_comb begin
      if (cfg_i.lvl) trig_o = (smp_i == cfg_i.pol);
      else           trig_o = cfg_i.pol ? rise : fall;
   end

   // set has priority over write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      status_q <= 1'b0;
      else if (cfg_i.cap_en && trig_o) status_q <= 1'b1;
      else if (clr_i)                  status_q <= 1'b0;
   end

   assign prev_o   = prev_q;
   assign status_o = status_q;

endmodule

// File: rtl/gil_regs.sv
module gil_regs
   import gil_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic                  wr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   input  logic [NUM_PINS-1:0]   status_i,
   output pin_cfg_t [NUM_PINS-1:0] cfg_o,
   output logic [NUM_PINS-1:0]   clr_o,
   output logic [DATA_W-1:0]     rdata_o
);

   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_PINS);

   if ((2 ** ADDR_W) <= NUM_PINS) begin : g_bad_addr
      $error("gil_regs: ADDR_W too small for NUM_PINS config words plus status");
   end
   if (DATA_W < NUM_PINS || DATA_W < CFG_W) begin : g_bad_data
      $error("gil_regs: DATA_W too narrow");
   end

   pin_cfg_t [NUM_PINS-1:0] cfg_q;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[i] <= '0;
         else if (wr_i && addr_i == ADDR_W'(i))
            cfg_q[i] <= pin_cfg_t'(wdata_i[CFG_W-1:0]);
      end
   end

   assign cfg_o = cfg_q;
   assign clr_o = (wr_i && addr_i == STAT_ADDR) ? wdata_i[NUM_PINS-1:0] : '0;

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (addr_i == ADDR_W'(i)) rdata_o = DATA_W'(cfg_q[i]);
      end
      if (addr_i == STAT_ADDR) rdata_o = DATA_W'(status_i);
   end

endmodule

// File: rtl/gil_summary.sv
module gil_summary #(
   parameter int NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] status_i,
   input  logic [NUM_PINS-1:0] rpt_en_i,
   output logic                irq_o
);

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status_i & rpt_en_i);
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch
   import gil_pkg::*;
#(
   parameter  int NUM_PINS    = 8,
   parameter  int ADDR_W      = 4,
   parameter  int SYNC_STAGES = 2,
   localparam int DATA_W      = imax(NUM_PINS, CFG_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] gpio_i,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq_o
);

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("gpio_irq_latch: NUM_PINS must be positive");
   end

   logic [NUM_PINS-1:0]     smp;
   logic [NUM_PINS-1:0]     prev_vec;
   logic [NUM_PINS-1:0]     trig_vec;
   logic [NUM_PINS-1:0]     status_q;
   logic [NUM_PINS-1:0]     clr_vec;
   logic [NUM_PINS-1:0]     cap_vec;
   logic [NUM_PINS-1:0]     rpt_vec;
   logic [NUM_PINS-1:0]     lvl_vec;
   pin_cfg_t [NUM_PINS-1:0] cfg;

   gil_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (gpio_i),
      .q_o   (smp)
   );

   gil_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (bus_addr),
      .wr_i     (bus_wr),
      .wdata_i  (bus_wdata),
      .status_i (status_q),
      .cfg_o    (cfg),
      .clr_o    (clr_vec),
      .rdata_o  (bus_rdata)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gil_pin_detect u_det (
         .clk      (clk),
         .rst_n    (rst_n),
         .smp_i    (smp[i]),
         .cfg_i    (cfg[i]),
         .clr_i    (clr_vec[i]),
         .prev_o   (prev_vec[i]),
         .trig_o   (trig_vec[i]),
         .status_o (status_q[i])
      );
      assign cap_vec[i] = cfg[i].cap_en;
      assign rpt_vec[i] = cfg[i].rpt_en;
      assign lvl_vec[i] = cfg[i].lvl;
   end

   gil_summary #(.NUM_PINS(NUM_PINS)) u_sum (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_q),
      .rpt_en_i (rpt_vec),
      .irq_o    (irq_o)
   );

endmodule

// File: rtl/gpio_irq_latch_chk.sv
module gpio_irq_latch_chk #(
   parameter int NUM_PINS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] smp,
   input logic [NUM_PINS-1:0] prev_vec,
   input logic [NUM_PINS-1:0] trig_vec,
   input logic [NUM_PINS-1:0] status_q,
   input logic [NUM_PINS-1:0] clr_vec,
   input logic [NUM_PINS-1:0] cap_vec,
   input logic [NUM_PINS-1:0] rpt_vec,
   input logic [NUM_PINS-1:0] lvl_vec,
   input logic                irq_o
);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_p
      // R2: capture disabled keeps a clear status bit clear
      a_r2_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
         (!status_q[i] && !cap_vec[i]) |=> !status_q[i]);
      // R4: only an acknowledge removes a set bit
      a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (status_q[i] && !clr_vec[i]) |=> status_q[i]);
      // R5: trigger with capture enabled sets, even against an acknowledge
      a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (trig_vec[i] && cap_vec[i]) |=> status_q[i]);
      // R7: edge mode without a transition latches nothing
      a_r7_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
         (!lvl_vec[i] && !status_q[i] && (smp[i] == prev_vec[i])) |=> !status_q[i]);
   end

   // R6: summary follows qualifying status one cycle later
   a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status_q & rpt_vec)) |=> irq_o);
   a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status_q & rpt_vec)) |=> !irq_o);

endmodule

bind gpio_irq_latch gpio_irq_latch_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp      (smp),
   .prev_vec (prev_vec),
   .trig_vec (trig_vec),
   .status_q (status_q),
   .clr_vec  (clr_vec),
   .cap_vec  (cap_vec),
   .rpt_vec  (rpt_vec),
   .lvl_vec  (lvl_vec),
   .irq_o    (irq_o)
);

// File: tb/tb_gpio_irq_latch.sv
module tb_gpio_irq_latch;

   localparam int NP   = 8;
   localparam int AW   = 4;
   localparam int DW   = 8;
   localparam logic [AW-1:0] STAT = AW'(NP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] gpio = '0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;

   int n_vec = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   gpio_irq_latch #(.NUM_PINS(NP), .ADDR_W(AW), .SYNC_STAGES(2)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .gpio_i    (gpio),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      for (int i = 0; i < NP; i++) begin
         rd(AW'(i), v);
         chk("R1 cfg reset", 32'(v), 0);
      end
      rd(STAT, v);
      chk("R1 status reset", 32'(v), 0);
      chk("R1 irq reset", 32'(irq), 0);
   endtask

   task automatic t_regmap();
      logic [DW-1:0] v;
      wr(4'd7, 8'h0B);
      rd(4'd7, v);
      chk("R10 cfg readback", 32'(v), 32'h0B);
      rd(4'd12, v);
      chk("R10 unmapped reads zero", 32'(v), 0);
      wr(4'd7, 8'h00);
   endtask

   task automatic t_level_high();
      logic [DW-1:0] v;
      wr(4'd0, 8'h0F);
      gpio[0] = 1'b1;
      step(2);
      rd(STAT, v);
      chk("R9 status not yet after two edges", 32'(v), 0);
      step(1);
      rd(STAT, v);
      chk("R9 status after third edge", 32'(v), 32'h01);
      chk("R9 irq not yet", 32'(irq), 0);
      step(1);
      chk("R9 irq after fourth edge", 32'(irq), 1);
      wr(STAT, 8'h01);
      rd(STAT, v);
      chk("R5 ack while active is overridden", 32'(v), 32'h01);
      gpio[0] = 1'b0;
      step(4);
      rd(STAT, v);
      chk("R4 sticky after source drops", 32'(v), 32'h01);
      wr(STAT, 8'h00);
      rd(STAT, v);
      chk("R4 zero write keeps bit", 32'(v), 32'h01);
      wr(STAT, 8'h01);
      rd(STAT, v);
      chk("R4 one write clears bit", 32'(v), 0);
      chk("R6 irq still high one cycle", 32'(irq), 1);
      step(1);
      chk("R6 irq drops next cycle", 32'(irq), 0);
      wr(4'd0, 8'h00);
   endtask

   task automatic t_level_low();
      logic [DW-1:0] v;
      wr(4'd6, 8'h0D);
      step(1);
      rd(STAT, v);
      chk("R10 active-low level latches", 32'(v), 32'h40);
      gpio[6] = 1'b1;
      step(3);
      wr(STAT, 8'h40);
      rd(STAT, v);
      chk("R10 active-low cleared when high", 32'(v), 0);
      wr(4'd6, 8'h00);
      step(1);
      chk("R6 irq low after clear", 32'(irq), 0);
   endtask

   task automatic t_capture_off();
      logic [DW-1:0] v;
      wr(4'd1, 8'h0B);
      gpio[1] = 1'b1;
      step(5);
      rd(STAT, v);
      chk("R2 no latch with capture off", 32'(v), 0);
      chk("R2 no irq with capture off", 32'(irq), 0);
      gpio[1] = 1'b0;
      step(3);
      wr(4'd1, 8'h00);
   endtask

   task automatic t_report_off();
      logic [DW-1:0] v;
      wr(4'd2, 8'h07);
      gpio[2] = 1'b1;
      step(4);
      rd(STAT, v);
      chk("R3 status latches with report off", 32'(v), 32'h04);
      chk("R3 irq stays low", 32'(irq), 0);
      wr(4'd2, 8'h0F);
      chk("R6 irq not yet after enable write", 32'(irq), 0);
      step(1);
      chk("R6 irq after report enable", 32'(irq), 1);
      gpio[2] = 1'b0;
      step(3);
      wr(STAT, 8'h04);
      wr(4'd2, 8'h00);
      chk("R6 irq low after cleanup", 32'(irq), 0);
   endtask

   task automatic t_edges();
      logic [DW-1:0] v;
      wr(4'd3, 8'h0E);
      gpio[3] = 1'b1;
      step(2);
      rd(STAT, v);
      chk("R7 rising not yet", 32'(v), 0);
      step(1);
      rd(STAT, v);
      chk("R7 rising latched", 32'(v), 32'h08);
      wr(STAT, 8'h08);
      step(5);
      rd(STAT, v);
      chk("R7 held high no relatch", 32'(v), 0);
      gpio[3] = 1'b0;
      step(4);
      rd(STAT, v);
      chk("R7 falling ignored on rising pin", 32'(v), 0);
      wr(4'd3, 8'h00);
      gpio[4] = 1'b1;
      step(3);
      wr(4'd4, 8'h0C);
      step(3);
      rd(STAT, v);
      chk("R7 held high on falling pin", 32'(v), 0);
      gpio[4] = 1'b0;
      step(3);
      rd(STAT, v);
      chk("R7 falling latched", 32'(v), 32'h10);
      wr(STAT, 8'h10);
      wr(4'd4, 8'h00);
   endtask

   task automatic t_rearm();
      logic [DW-1:0] v;
      wr(4'd5, 8'h0A);
      gpio[5] = 1'b1;
      step(4);
      wr(4'd5, 8'h0E);
      step(4);
      rd(STAT, v);
      chk("R8 enabling capture makes no edge", 32'(v), 0);
      gpio[5] = 1'b0;
      step(3);
      gpio[5] = 1'b1;
      step(3);
      rd(STAT, v);
      chk("R8 real edge after rearm", 32'(v), 32'h20);
      wr(STAT, 8'h20);
      wr(4'd5, 8'h00);
      gpio[5] = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_regmap();
      t_level_high();
      t_level_low();
      t_capture_off();
      t_report_off();
      t_edges();
      t_rearm();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule